// File: doc/BRIEF.md
# Debug Session State Sequencer

This block runs the control side of an on-chip debug session. Software arms a session, and the sequencer starts at stage one. It then moves through a fixed chain of trigger stages as comparator match pulses arrive. A session ends in one of two ways, and they differ. A software disarm leaves the last stage code on view. An internal end event, raised either from outside or when the final stage is reached, drops the sequencer back to the idle code.

Alongside the sequencer, the block counts trace lines stored into a 64-entry trace buffer. Lines are counted only while a session is armed, and the count stops at the buffer depth. A sticky full flag shows that every buffer entry holds valid data, even when the count has since been cleared. Two reset inputs drive the block. Power-on reset clears everything. System reset clears the session, but the full flag survives it.

The block reports through two read-only bytes: a status byte and a line-count byte. It also drives the stage code out on its own port.

Top module: `dbg_seq_ctrl`

## Requirements
- R1: After power-on reset, `status_o`, `line_cnt_o` and `state_o` are all zero.
- R2: A pulse on `arm_set_i` arms the session and sets the stage code to 001 on the next clock edge. It takes priority over every other input in that cycle, including `arm_clr_i`.
- R3: While armed, the stage code advances 001→010 on `match_i[0]`, 010→011 on `match_i[1]` and 011→100 on `match_i[2]`. A match bit that does not belong to the current stage is ignored.
- R4: The final code 100 lasts exactly one cycle while armed. On the next edge the session disarms and the code becomes 000. Match pulses have no effect while disarmed.
- R5: A software disarm (`arm_clr_i` while armed) ends the session and keeps the stage code unchanged. Later match pulses do not move it.
- R6: `end_evt_i` while armed (without `arm_set_i` or `arm_clr_i`) ends the session, and the stage code becomes 000 on the next edge.
- R7: The line count in `line_cnt_o[6:0]` rises by one per `trace_store_i` cycle while armed. It ignores strobes while disarmed and stops at 64.
- R8: The full flag sets in the same edge in which the count reaches 64. It reads at `status_o[7]` and also at `line_cnt_o[7]`.
- R9: `arm_set_i` clears both the full flag and the line count.
- R10: System reset (`sys_rst_n` low) clears the arm state, the stage code and the line count, and keeps the full flag. Power-on reset (`por_n` low) also clears the full flag.
- R11: `status_o` holds the full flag at bit 7, zeros at bits 6:3 and the stage code at bits 2:0. The stage code never takes the values 101, 110 or 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst_n | input | 1 | System reset, asynchronous, active low |
| arm_set_i | input | 1 | One-cycle pulse: arm a new session |
| arm_clr_i | input | 1 | One-cycle pulse: software disarm |
| match_i | input | 3 | Trigger match pulses for stages one, two and three (bit 0, bit 1, bit 2) |
| end_evt_i | input | 1 | Internal end-of-session event |
| trace_store_i | input | 1 | A trace line was stored this cycle |
| status_o | output | 8 | Status byte: {full, 4'b0, stage code} |
| line_cnt_o | output | 8 | Line-count byte: {full, count[6:0]} |
| state_o | output | 3 | Stage code |

## Verification
The assertions are disabled while the synchronized session reset is low. They take for granted that no control pulse arrives in the two cycles after a reset is released, because inputs in that window are dropped by design. The bench keeps every input idle through each reset and for several cycles after release. Control pulses such as arm, disarm and end are one cycle wide in the directed part, and in the swept part they come from an LFSR at low rates. Match and store pulses come more often, so the bench reaches every stage, both kinds of session end and a saturated count.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ONE   = 3'd1,
    ST_TWO   = 3'd2,
    ST_THREE = 3'd3,
    ST_FINAL = 3'd4
  } seq_state_e;

  localparam int STATUS_W   = 8;
  localparam int FULL_BIT   = 7;
  localparam int STAGE_W    = 3;
  localparam int NUM_MATCH  = 3;
endpackage

// File: rtl/dbg_rst_sync.sv
module dbg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
  import dbg_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm_set_i,
  input  logic                 arm_clr_i,
  input  logic [NUM_MATCH-1:0] match_i,
  input  logic                 end_evt_i,
  output logic                 armed_o,
  output logic [STAGE_W-1:0]   state_o
);
  seq_state_e state_q, state_d;
  logic       armed_q, armed_d;
  logic       fin_end;
  logic       upd_en;

  // reaching the final stage raises a one-cycle internal end
  assign fin_end = armed_q && (state_q == ST_FINAL);

  always_comb begin
    state_d = state_q;
    armed_d = armed_q;
    if (arm_set_i) begin
      armed_d = 1'b1;
      state_d = ST_ONE;
    end else if (armed_q) begin
      if (arm_clr_i) begin
        armed_d = 1'b0;               // software disarm keeps the code
      end else if (end_evt_i || fin_end) begin
        armed_d = 1'b0;
        state_d = ST_IDLE;
      end else begin
        unique case (state_q)
          ST_ONE:   if (match_i[0]) state_d = ST_TWO;
          ST_TWO:   if (match_i[1]) state_d = ST_THREE;
          ST_THREE: if (match_i[2]) state_d = ST_FINAL;
          default:  state_d = state_q;
        endcase
      end
    end
  end

  assign upd_en = arm_set_i || armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      armed_q <= 1'b0;
    end else if (upd_en) begin
      state_q <= state_d;
      armed_q <= armed_d;
    end
  end

  assign armed_o = armed_q;
  assign state_o = state_q;
endmodule

// File: rtl/dbg_trace_cnt.sv
module dbg_trace_cnt #(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             por_rst_n,
  input  logic             sys_rst_n,
  input  logic             clear_i,
  input  logic             armed_i,
  input  logic             store_i,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full_q, full_d;
  logic             cnt_en;

  assign cnt_en = clear_i || (armed_i && store_i && (cnt_q != CNT_MAX));

  always_comb begin
    if (clear_i) cnt_d = '0;
    else         cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    if (clear_i)              full_d = 1'b0;
    else if (cnt_d == CNT_MAX) full_d = 1'b1;
    else                      full_d = full_q;
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n)  cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // full flag lives in the power-on domain only
  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n)  full_q <= 1'b0;
    else if (cnt_en) full_q <= full_d;
  end

  assign full_o  = full_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/dbg_seq_ctrl.sv
module dbg_seq_ctrl
  import dbg_seq_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 sys_rst_n,
  input  logic                 arm_set_i,
  input  logic                 arm_clr_i,
  input  logic [NUM_MATCH-1:0] match_i,
  input  logic                 end_evt_i,
  input  logic                 trace_store_i,
  output logic [STATUS_W-1:0]  status_o,
  output logic [CNT_W:0]       line_cnt_o,
  output logic [STAGE_W-1:0]   state_o
);
  logic                por_s_n;
  logic                sys_s_n;
  logic                sys_arst_n;
  logic                armed_w;
  logic                full_w;
  logic [CNT_W-1:0]    cnt_w;
  logic [STAGE_W-1:0]  stage_w;

  assign sys_arst_n = por_n & sys_rst_n;

  dbg_rst_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk(clk), .arst_n(por_n), .srst_n_o(por_s_n)
  );

  dbg_rst_sync #(.STAGES(SYNC_STAGES)) u_sys_sync (
    .clk(clk), .arst_n(sys_arst_n), .srst_n_o(sys_s_n)
  );

  dbg_seq_fsm u_fsm (
    .clk(clk), .rst_n(sys_s_n),
    .arm_set_i(arm_set_i), .arm_clr_i(arm_clr_i),
    .match_i(match_i), .end_evt_i(end_evt_i),
    .armed_o(armed_w), .state_o(stage_w)
  );

  dbg_trace_cnt #(.DEPTH(DEPTH)) u_cnt (
    .clk(clk), .por_rst_n(por_s_n), .sys_rst_n(sys_s_n),
    .clear_i(arm_set_i), .armed_i(armed_w), .store_i(trace_store_i),
    .full_o(full_w), .count_o(cnt_w)
  );

  always_comb begin
    status_o = '0;
    status_o[FULL_BIT] = full_w;
    status_o[STAGE_W-1:0] = stage_w;
  end

  assign line_cnt_o = {full_w, cnt_w};
  assign state_o    = stage_w;
endmodule

// File: rtl/dbg_seq_chk.sv
module dbg_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       arm_set_i,
  input logic       arm_clr_i,
  input logic       end_evt_i,
  input logic       armed,
  input logic [2:0] state_o,
  input logic [7:0] status_o,
  input logic [7:0] line_cnt_o
);
  AST_ARM_ENTERS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    arm_set_i |=> (state_o == 3'd1)); // R2

  AST_ARM_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    arm_set_i |=> (!status_o[7] && line_cnt_o[6:0] == 7'd0)); // R9

  AST_FINAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && state_o == 3'd4 && !arm_set_i && !arm_clr_i) |=> (state_o == 3'd0 && !armed)); // R4

  AST_SW_DISARM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && arm_clr_i && !arm_set_i) |=> $stable(state_o)); // R5

  AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && end_evt_i && !arm_set_i && !arm_clr_i) |=> (state_o == 3'd0)); // R6

  AST_IDLE_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !arm_set_i) |=> $stable(state_o)); // R4

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    line_cnt_o[6:0] <= 7'd64); // R7

  AST_FULL_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[7] == line_cnt_o[7]); // R8

  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd4); // R11
endmodule

bind dbg_seq_ctrl dbg_seq_chk chk_i (
  .clk(clk), .rst_n(sys_s_n),
  .arm_set_i(arm_set_i), .arm_clr_i(arm_clr_i), .end_evt_i(end_evt_i),
  .armed(armed_w), .state_o(state_o), .status_o(status_o),
  .line_cnt_o(line_cnt_o)
);

// File: tb/dbg_seq_ctrl_tb_top.sv
module dbg_seq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       por_n, sys_rst_n;
  logic       arm_set_i, arm_clr_i, end_evt_i, trace_store_i;
  logic [2:0] match_i;
  logic [7:0] status_o, line_cnt_o;
  logic [2:0] state_o;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  // reference state
  int m_st, m_cnt;
  bit m_armed, m_full;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  dbg_seq_ctrl dut_i (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .arm_set_i(arm_set_i), .arm_clr_i(arm_clr_i), .match_i(match_i),
    .end_evt_i(end_evt_i), .trace_store_i(trace_store_i),
    .status_o(status_o), .line_cnt_o(line_cnt_o), .state_o(state_o)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input bit as, input bit ac, input logic [2:0] m,
                      input bit ev, input bit ts, input string tag);
    arm_set_i = as; arm_clr_i = ac; match_i = m; end_evt_i = ev; trace_store_i = ts;
    @(negedge clk);
    if (as) begin
      m_armed = 1; m_st = 1; m_cnt = 0; m_full = 0;
    end else begin
      if (m_armed && ts && m_cnt < 64) begin
        m_cnt++;
        if (m_cnt == 64) m_full = 1;
      end
      if (m_armed) begin
        if (ac) m_armed = 0;
        else if (ev || m_st == 4) begin m_armed = 0; m_st = 0; end
        else if (m_st == 1 && m[0]) m_st = 2;
        else if (m_st == 2 && m[1]) m_st = 3;
        else if (m_st == 3 && m[2]) m_st = 4;
      end
    end
    check({tag, " state"}, {5'd0, state_o}, 8'(m_st));
    check({tag, " status"}, status_o, {m_full, 4'b0, 3'(m_st)});
    check({tag, " linecnt"}, line_cnt_o, {m_full, 7'(m_cnt)});
    arm_set_i = 0; arm_clr_i = 0; match_i = 0; end_evt_i = 0; trace_store_i = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(0, 0, 3'b0, 0, 0, tag);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    por_n = 0; sys_rst_n = 1;
    arm_set_i = 0; arm_clr_i = 0; match_i = 0; end_evt_i = 0; trace_store_i = 0;
    m_st = 0; m_cnt = 0; m_armed = 0; m_full = 0;
    repeat (3) @(negedge clk);
    por_n = 1;
    repeat (4) @(negedge clk);
    idle(2, "R1 reset");

    // R2: arm, and arm wins over disarm in the same cycle
    tick(1, 0, 3'b0, 0, 0, "R2 arm");
    tick(1, 1, 3'b0, 0, 0, "R2 arm priority");
    // R3: ordered advance, wrong matches ignored
    tick(0, 0, 3'b110, 0, 0, "R3 wrong match s1");
    tick(0, 0, 3'b001, 0, 0, "R3 s1->s2");
    tick(0, 0, 3'b101, 0, 0, "R3 wrong match s2");
    tick(0, 0, 3'b010, 0, 0, "R3 s2->s3");
    tick(0, 0, 3'b011, 0, 0, "R3 wrong match s3");
    tick(0, 0, 3'b100, 0, 0, "R3 s3->final");
    // R4: final lasts one cycle, then idle and matches ignored
    tick(0, 0, 3'b111, 0, 0, "R4 final ends");
    tick(0, 0, 3'b111, 0, 0, "R4 disarmed ignore");
    // R5: software disarm keeps code
    tick(1, 0, 3'b0, 0, 0, "R5 arm");
    tick(0, 0, 3'b001, 0, 0, "R5 advance");
    tick(0, 1, 3'b0, 0, 0, "R5 sw disarm");
    tick(0, 0, 3'b010, 0, 0, "R5 hold after disarm");
    tick(0, 1, 3'b0, 1, 0, "R5 clr when idle");
    // R6: end event forces idle
    tick(1, 0, 3'b0, 0, 0, "R6 arm");
    tick(0, 0, 3'b001, 0, 0, "R6 advance");
    tick(0, 0, 3'b010, 0, 0, "R6 advance");
    tick(0, 0, 3'b0, 1, 0, "R6 end event");
    tick(0, 0, 3'b001, 0, 0, "R6 after end");
    // R7: counting only while armed
    tick(1, 0, 3'b0, 0, 1, "R7 arm");
    for (int i = 0; i < 10; i++) tick(0, 0, 3'b0, 0, 1, "R7 count");
    tick(0, 1, 3'b0, 0, 1, "R7 disarm");
    for (int i = 0; i < 5; i++) tick(0, 0, 3'b0, 0, 1, "R7 ignored when disarmed");
    // R8: saturation and full flag
    tick(1, 0, 3'b0, 0, 0, "R9 arm clears");
    for (int i = 0; i < 70; i++) tick(0, 0, 3'b0, 0, 1, "R8 fill");
    tick(1, 0, 3'b0, 0, 0, "R9 rearm clears full");
    for (int i = 0; i < 64; i++) tick(0, 0, 3'b0, 0, 1, "R8 refill");
    tick(0, 0, 3'b001, 0, 0, "R8 advance");
    // R10: system reset keeps full flag
    sys_rst_n = 0;
    m_armed = 0; m_st = 0; m_cnt = 0;
    repeat (2) @(negedge clk);
    sys_rst_n = 1;
    repeat (3) @(negedge clk);
    idle(1, "R10 sys reset keeps full");
    por_n = 0;
    m_full = 0;
    repeat (2) @(negedge clk);
    por_n = 1;
    repeat (3) @(negedge clk);
    idle(1, "R10 por clears full");

    // R11: swept stimulus, field layout and code range
    for (int phase = 0; phase < 2; phase++) begin
      for (int i = 0; i < 4000; i++) begin
        bit as, ac, ev;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        as = (phase == 0) ? (lfsr[4:0] == 5'd0) : (lfsr[7:0] == 8'd0);
        ac = (phase == 0) ? (lfsr[10:5] == 6'd1) : 1'b0;
        ev = (phase == 0) ? (lfsr[15:10] == 6'd2) : (lfsr[15:8] == 8'd3);
        tick(as, ac, lfsr[7:5] & lfsr[10:8], ev, lfsr[11], "R11 sweep");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule